// File: doc/BRIEF.md
# Speech Sample Bank Register

This block holds the base offset that positions a 256 KB window of speech-sample ROM inside a larger sample memory. A CPU write strobe and an 8-bit data byte load it through one write-only address. The registered offset is added outside the block to the address that the sample playback engine produces. The playback engine itself is not part of the block.

A static input gives how many 256 KB banks are fitted on the board, and that count selects one of two decodings. With three banks or fewer, two flag bits of the byte pick one of three fixed windows. With four or more banks, the low three bits form an index `v`, and the window becomes bank `v - 1`. In that mode a zero index is a no-op that keeps the current window. The output changes on the clock edge that follows the strobe, and a synchronous active-high reset returns it to bank zero.

Top module: `sample_bank_sel`

## Requirements
- R1: While `rst` is high at a rising clock edge, `bank_base` becomes 0x00000 at that edge, whatever the other inputs are.
- R2: At an edge where `wr_en` is low, `bank_base` keeps its value.
- R3: Small mode (`banks_fitted` of 3 or less): a write with data bit 2 clear sets `bank_base` to 0x00000. All other data bits are ignored.
- R4: Small mode: a write with data bit 2 set and data bit 0 set sets `bank_base` to 0x40000.
- R5: Small mode: a write with data bit 2 set and data bit 0 clear sets `bank_base` to 0x80000. Bits 7:3 and bit 1 are ignored.
- R6: Large mode (`banks_fitted` of 4 or more): only data bits 2:0 are used. A nonzero value v sets `bank_base` to (v-1)*0x40000, so v=7 gives 0x180000.
- R7: Large mode: a write whose bits 2:0 are zero leaves `bank_base` unchanged, whatever bits 7:3 hold.
- R8: The mode boundary lies between 3 and 4 fitted banks. For example, data 0x04 gives 0x80000 with 3 banks and 0xC0000 with 4 banks.
- R9: A write takes effect at the first rising edge where `wr_en` is sampled high. Before that edge `bank_base` still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe for the register address |
| wr_data | input | 8 | CPU data byte |
| banks_fitted | input | 4 | Static count of fitted 256 KB banks |
| bank_base | output | 21 | Registered byte offset of the selected window |

## Verification
On every cycle, the assertions check that the offset holds when no write is strobed, that a zero index in large mode changes nothing, and that small mode only ever lands on one of its three windows. They also check that a nonzero large-mode index lands on the expected bank one edge later, and that reset clears the offset. The bench scenarios are needed to show the exact window chosen for each flag combination in small mode, that ignored bits have no effect, and the behaviour at the 3/4 boundary with identical data. The bench also shows that the output does not move before the edge that samples the strobe.

// File: rtl/sbk_pkg.sv
package sbk_pkg;

    localparam int DATA_W     = 8;
    localparam int IDX_W      = 3;
    localparam int SMALL_MAX  = 3;

    typedef enum logic {
        MODE_FLAGS = 1'b0,
        MODE_INDEX = 1'b1
    } sbk_mode_e;

    typedef struct packed {
        logic             load;
        logic [IDX_W-1:0] idx;
    } sbk_sel_t;

    // Three-way flag decode used on boards with few banks.
    function automatic sbk_sel_t flag_decode(input logic [DATA_W-1:0] d);
        sbk_sel_t s;
        s.load = 1'b1;
        if (!d[2])
            s.idx = 3'd0;
        else if (d[0])
            s.idx = 3'd1;
        else
            s.idx = 3'd2;
        return s;
    endfunction

    // Index decode used on boards with many banks; zero means keep.
    function automatic sbk_sel_t index_decode(input logic [DATA_W-1:0] d);
        sbk_sel_t s;
        s.load = (d[IDX_W-1:0] != '0);
        s.idx  = d[IDX_W-1:0] - 3'd1;
        return s;
    endfunction

endpackage

// File: rtl/sbk_decode.sv
module sbk_decode
    import sbk_pkg::*;
#(
    parameter int COUNT_W = 4
) (
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [COUNT_W-1:0] banks_fitted,
    output sbk_mode_e          mode,
    output sbk_sel_t           sel
);

    localparam logic [COUNT_W-1:0] LIMIT = COUNT_W'(SMALL_MAX);

    always_comb begin
        mode = (banks_fitted <= LIMIT) ? MODE_FLAGS : MODE_INDEX;
        case (mode)
            MODE_FLAGS: sel = flag_decode(wr_data);
            default:    sel = index_decode(wr_data);
        endcase
    end

endmodule

// File: rtl/sbk_base_reg.sv
module sbk_base_reg
    import sbk_pkg::*;
#(
    parameter int BANK_SHIFT = 18,
    localparam int BASE_W    = IDX_W + BANK_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  idx,
    output logic [BASE_W-1:0] base
);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (load_en)
            idx_q <= idx;
    end

    assign base = {idx_q, {BANK_SHIFT{1'b0}}};

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(base));

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (base == '0));

endmodule

// File: rtl/sample_bank_sel.sv
module sample_bank_sel
    import sbk_pkg::*;
#(
    parameter int COUNT_W    = 4,
    parameter int BANK_SHIFT = 18,
    localparam int BASE_W    = IDX_W + BANK_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [COUNT_W-1:0] banks_fitted,
    output logic [BASE_W-1:0]  bank_base
);

    sbk_mode_e mode;
    sbk_sel_t  sel;

    sbk_decode #(.COUNT_W(COUNT_W)) u_decode (
        .wr_data      (wr_data),
        .banks_fitted (banks_fitted),
        .mode         (mode),
        .sel          (sel)
    );

    sbk_base_reg #(.BANK_SHIFT(BANK_SHIFT)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .load_en (wr_en && sel.load),
        .idx     (sel.idx),
        .base    (bank_base)
    );

    localparam logic [COUNT_W-1:0] LIM = COUNT_W'(SMALL_MAX);

    assert_wr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(bank_base));

    assert_zero_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && banks_fitted > LIM && wr_data[2:0] == 3'd0) |=> $stable(bank_base));

    assert_flag_range_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && banks_fitted <= LIM) |=>
        (bank_base == '0 || bank_base == {3'd1, {BANK_SHIFT{1'b0}}}
                         || bank_base == {3'd2, {BANK_SHIFT{1'b0}}}));

    assert_index_load_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && banks_fitted > LIM && wr_data[2:0] != 3'd0) |=>
        (bank_base == {($past(wr_data[2:0]) - 3'd1), {BANK_SHIFT{1'b0}}}));

endmodule

// File: tb/sample_bank_sel_tb.sv
module sample_bank_sel_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [3:0]  banks_fitted = 4'd3;
    logic [20:0] bank_base;

    int checks = 0;
    int errors = 0;
    int expv = 0;
    string cur_req = "R1";
    bit finished = 0;

    always #5 clk = ~clk;

    sample_bank_sel u_dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .banks_fitted (banks_fitted),
        .bank_base    (bank_base)
    );

    // Behavioural reference model, updated at every rising edge.
    always @(posedge clk) begin
        if (rst) expv = 0;
        else if (wr_en) begin
            if (banks_fitted <= 3) begin
                if ((wr_data & 8'h04) == 0) expv = 0;
                else if ((wr_data & 8'h01) != 0) expv = 'h40000;
                else expv = 'h80000;
            end else begin
                int v;
                v = wr_data & 7;
                if (v != 0) expv = (v - 1) * 'h40000;
            end
        end
    end

    task automatic check(input string req, input int exp_val);
        checks++;
        if (int'(bank_base) != exp_val) begin
            errors++;
            $display("FAIL %s: bank_base=%h expected=%h", req, bank_base, exp_val);
        end
    endtask

    // Compare on every clock, away from the active edge.
    always @(negedge clk) if (!finished) check(cur_req, expv);

    task automatic wr(input string req, input logic [7:0] d);
        @(negedge clk);
        cur_req = req;
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'hA5;
    endtask

    task automatic idle(input string req, input int n);
        cur_req = req;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle("R1", 1);

        // small mode
        banks_fitted = 4'd3;
        wr("R4", 8'hFF);
        idle("R2", 3);
        wr("R5", 8'h04);
        wr("R5", 8'hFE);
        wr("R3", 8'hFB);
        wr("R4", 8'h05);
        wr("R3", 8'h00);
        banks_fitted = 4'd1;
        wr("R5", 8'h0E);
        wr("R4", 8'h0D);

        // R9: before the sampling edge the output keeps the old value
        @(negedge clk);
        cur_req = "R9";
        wr_en = 1'b1;
        wr_data = 8'h04;
        #1 check("R9", 'h40000);
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R9", 'h80000);

        // mode boundary R8
        banks_fitted = 4'd4;
        wr("R8", 8'h04);
        #1 check("R8", 'hC0000);

        // large mode
        for (int v = 1; v < 8; v++) wr("R6", 8'(v) | 8'hF0);
        wr("R7", 8'hF8);
        wr("R7", 8'h00);
        idle("R2", 2);
        banks_fitted = 4'd8;
        wr("R6", 8'h02);
        wr("R7", 8'h08);

        // mid-run reset
        @(negedge clk);
        cur_req = "R1";
        rst = 1'b1;
        wr_en = 1'b1;
        wr_data = 8'h07;
        @(negedge clk);
        rst = 1'b0;
        wr_en = 1'b0;
        idle("R1", 2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule